// File: doc/BRIEF.md
# Saturating Millisecond Stopwatch with Scanned Seven-Segment Output

This block keeps an elapsed time of up to fifty-nine minutes, fifty-nine seconds and nine hundred ninety-nine milliseconds. The time is held as seven BCD digits with mixed radix, shown as MM:SS.sss. While the enable input is high, the time advances by one millisecond on each frame tick. A synchronous clear input returns the time to zero and overrides the enable. The count does not wrap. It stops at its largest value and raises an overflow flag.

The same register set drives a time-multiplexed seven-segment display. A free-running scan counter steps through eight slots. Each slot lasts `SLOT_CLKS` clocks. Slots 0 to 6 each enable one digit and place that digit's segment pattern on a shared bus. Slot 7 is an idle slot. The end of slot 7 marks one full frame, and that moment is the millisecond tick. Leading zeros in the three highest digits are suppressed. A separate input switches every segment off.

Top module: `swd_timer`

## Requirements
- R1: While `enable_count` is high and `reset_count` is low, the count advances by exactly one on every frame tick. A frame is 8 × `SLOT_CLKS` clocks, and the tick falls on the last clock of slot 7. Each digit counts modulo its radix from `DIGIT_RADIX` and carries into the next digit. The default radices, from tens of minutes down to milliseconds, are 6,10,6,10,10,10,10.
- R2: While `enable_count` is low, the count keeps its value.
- R3: A clock edge with `reset_count` high sets every digit to 0, whatever `enable_count` is doing.
- R4: When every digit holds radix−1, the count stays there and `ov_flag` is high. `ov_flag` is low for every other count.
- R5: The scan slot advances once every `SLOT_CLKS` clocks and cycles through 0 to 7. In slot k < 7, `digit_en` is one-hot with bit k set. Bit 0 is the millisecond units digit and bit 6 is tens of minutes. In slot 7, `digit_en` is all zero.
- R6: `seg` carries the shown digit's pattern, active high, with bit 0 = a through bit 6 = g. The values for 0 to 9 are 3F,06,5B,4F,66,6D,7D,07,7F,6F in hex.
- R7: Digit 6 is blanked (`seg` = 0) when it is zero. Digit 5 is blanked when it and digit 6 are zero. Digit 4 is blanked when it, digit 5 and digit 6 are all zero. Digits 0 to 3 are never blanked, so a cleared count shows 0.000.
- R8: While `blank_display` is high, `seg` is 0 in every slot. The scan and the count keep running.
- R9: During slot 7, `seg` is 0.
- R10: After `rst_n` is released, the block is in slot 0 with a zero count. It shows the pattern 3F on digit 0, and `ov_flag` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_count | input | 1 | Count advances on frame ticks while high |
| reset_count | input | 1 | Synchronous clear of the count; overrides enable |
| blank_display | input | 1 | Forces all segments off |
| digit_en | output | 7 | One-hot digit select; bit 0 = ms units, bit 6 = tens of minutes |
| seg | output | 7 | Shared segment bus, bit 0 = a … bit 6 = g, active high |
| ov_flag | output | 1 | High while the count sits at its maximum |

## Verification
Two instances run from the same stimulus. One uses the default radices. The other uses radices of 2 and 3, so that it saturates after 287 ticks and shows leading-zero patterns where a zero digit sits below a nonzero one. The stimulus includes long enabled runs, which test carry and saturation. Enable-low windows test holding. Single-clock and multi-frame clears, applied with enable high, test clear priority. A blanking window and a pseudo-random enable pattern show whether ticks are counted only on the correct frame edge.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int NDIG   = 7;
  localparam int NSLOT  = 8;
  localparam int SLOT_W = $clog2(NSLOT);

  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;

  // segment pattern, bit0 = a ... bit6 = g, active high
  function automatic seg_t bcd_to_seg(bcd_t v);
    case (v)
      4'd0:    return 7'h3F;
      4'd1:    return 7'h06;
      4'd2:    return 7'h5B;
      4'd3:    return 7'h4F;
      4'd4:    return 7'h66;
      4'd5:    return 7'h6D;
      4'd6:    return 7'h7D;
      4'd7:    return 7'h07;
      4'd8:    return 7'h7F;
      4'd9:    return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // next value of a digit of the given radix
  function automatic bcd_t digit_step(bcd_t v, bcd_t radix);
    return (v == bcd_t'(radix - 4'd1)) ? 4'd0 : bcd_t'(v + 4'd1);
  endfunction
endpackage

// File: rtl/swd_scan.sv
module swd_scan
  import swd_pkg::*;
#(
  parameter int SLOT_CLKS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot,
  output logic              tick
);
  localparam int PW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [PW-1:0] PLAST = PW'(SLOT_CLKS - 1);
  localparam logic [SLOT_W-1:0] SLAST = SLOT_W'(NSLOT - 1);

  logic [PW-1:0] presc;
  logic          slot_adv;

  assign slot_adv = (presc == PLAST);
  assign tick     = slot_adv && (slot == SLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      slot  <= '0;
    end else begin
      presc <= slot_adv ? '0 : PW'(presc + 1'b1);
      if (slot_adv) slot <= (slot == SLAST) ? '0 : SLOT_W'(slot + 1'b1);
    end
  end
endmodule

// File: rtl/swd_bcd_chain.sv
module swd_bcd_chain
  import swd_pkg::*;
#(
  parameter logic [NDIG-1:0][3:0] RADIX = {4'd6, 4'd10, 4'd6, 4'd10, 4'd10, 4'd10, 4'd10}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 enable,
  input  logic                 clear,
  output bcd_t [NDIG-1:0]      digits,
  output logic                 at_max
);
  logic [NDIG:0]   carry;
  logic [NDIG-1:0] top;

  assign at_max   = &top;
  assign carry[0] = tick && enable && !at_max;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    assign top[d]     = (digits[d] == bcd_t'(RADIX[d] - 4'd1));
    assign carry[d+1] = carry[d] && top[d];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        digits[d] <= '0;
      else if (clear)    digits[d] <= '0;
      else if (carry[d]) digits[d] <= digit_step(digits[d], RADIX[d]);
    end
  end
endmodule

// File: rtl/swd_display.sv
module swd_display
  import swd_pkg::*;
#(
  parameter int LEAD_BLANK = 3
) (
  input  logic [SLOT_W-1:0] slot,
  input  bcd_t [NDIG-1:0]   digits,
  input  logic              blank_all,
  output logic [NDIG-1:0]   digit_en,
  output seg_t              seg
);
  logic [NDIG-1:0] lead;
  bcd_t            sel;
  logic            hide;

  for (genvar d = NDIG - 1; d >= 0; d--) begin : g_lead
    if (d == NDIG - 1) begin : g_top
      assign lead[d] = (digits[d] == 4'd0);
    end else if (d >= NDIG - LEAD_BLANK) begin : g_mid
      assign lead[d] = lead[d+1] && (digits[d] == 4'd0);
    end else begin : g_low
      assign lead[d] = 1'b0;
    end
  end

  always_comb begin
    sel      = '0;
    hide     = 1'b0;
    digit_en = '0;
    for (int d = 0; d < NDIG; d++) begin
      if (slot == SLOT_W'(d)) begin
        sel         = digits[d];
        hide        = lead[d];
        digit_en[d] = 1'b1;
      end
    end
    seg = (blank_all || hide || !(|digit_en)) ? '0 : bcd_to_seg(sel);
  end
endmodule

// File: rtl/swd_timer.sv
module swd_timer
  import swd_pkg::*;
#(
  parameter int SLOT_CLKS = 1000,
  parameter logic [6:0][3:0] DIGIT_RADIX = {4'd6, 4'd10, 4'd6, 4'd10, 4'd10, 4'd10, 4'd10}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_count,
  input  logic       reset_count,
  input  logic       blank_display,
  output logic [6:0] digit_en,
  output logic [6:0] seg,
  output logic       ov_flag
);
  logic [SLOT_W-1:0] slot;
  logic              tick;
  bcd_t [NDIG-1:0]   digits;
  logic              at_max;
  logic [4*NDIG-1:0] cnt_flat;
  logic              cnt_zero;

  swd_scan #(.SLOT_CLKS(SLOT_CLKS)) u_scan (
    .clk(clk), .rst_n(rst_n), .slot(slot), .tick(tick)
  );

  swd_bcd_chain #(.RADIX(DIGIT_RADIX)) u_chain (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable_count),
    .clear(reset_count), .digits(digits), .at_max(at_max)
  );

  swd_display #(.LEAD_BLANK(3)) u_disp (
    .slot(slot), .digits(digits), .blank_all(blank_display),
    .digit_en(digit_en), .seg(seg)
  );

  assign cnt_flat = digits;
  assign cnt_zero = (cnt_flat == '0);
  assign ov_flag  = at_max;
endmodule

// File: rtl/swd_timer_chk.sv
module swd_timer_chk #(
  parameter int CW = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable_count,
  input logic          reset_count,
  input logic          blank_display,
  input logic [6:0]    digit_en,
  input logic [6:0]    seg,
  input logic          ov_flag,
  input logic          tick,
  input logic [CW-1:0] cnt_flat,
  input logic          cnt_zero
);
  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digit_en)); // R5
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R5
  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    blank_display |-> (seg == 7'h00)); // R8
  AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_en == 7'h00) |-> (seg == 7'h00)); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reset_count |=> (cnt_zero && !ov_flag)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_count && !reset_count) |=> $stable(cnt_flat)); // R2
  AST_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reset_count) |=> $stable(cnt_flat)); // R1
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag && !reset_count) |=> (ov_flag && $stable(cnt_flat))); // R4
endmodule

bind swd_timer swd_timer_chk #(.CW(28)) u_chk (.*);

// File: tb/swd_timer_test.sv
module swd_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT       = 2;
  localparam int FRAME      = 8 * SLOT;
  localparam logic [6:0][3:0] SAT_RADIX = {4'd2, 4'd2, 4'd3, 4'd2, 4'd2, 4'd3, 4'd2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_count = 1'b0;
  logic reset_count = 1'b0;
  logic blank_display = 1'b0;
  logic [6:0] en_g [2];
  logic [6:0] seg_g [2];
  logic       ov_g [2];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  int rad [2][7];
  int maxv [2];
  int n [2];
  int k;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swd_timer #(.SLOT_CLKS(SLOT)) uut (
    .clk(clk), .rst_n(rst_n), .enable_count(enable_count), .reset_count(reset_count),
    .blank_display(blank_display), .digit_en(en_g[0]), .seg(seg_g[0]), .ov_flag(ov_g[0])
  );

  swd_timer #(.SLOT_CLKS(SLOT), .DIGIT_RADIX(SAT_RADIX)) uut_sat (
    .clk(clk), .rst_n(rst_n), .enable_count(enable_count), .reset_count(reset_count),
    .blank_display(blank_display), .digit_en(en_g[1]), .seg(seg_g[1]), .ov_flag(ov_g[1])
  );

  function automatic int dig(int i, int val, int d);
    int p = 1;
    for (int j = 0; j < d; j++) p = p * rad[i][j];
    return (val / p) % rad[i][d];
  endfunction

  function automatic logic [6:0] pattern(int v);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return t[v];
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    rad[0] = '{10, 10, 10, 10, 6, 10, 6};
    rad[1] = '{2, 3, 2, 2, 3, 2, 2};
    for (int i = 0; i < 2; i++) begin
      maxv[i] = 1;
      for (int d = 0; d < 7; d++) maxv[i] = maxv[i] * rad[i][d];
      maxv[i] = maxv[i] - 1;
      n[i] = 0;
    end
    k = 0;
  end

  // reference model: frame position and total count as plain integers
  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0;
      n[0] = 0;
      n[1] = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (reset_count) n[i] = 0;
        else if ((k % FRAME) == FRAME - 1 && enable_count && n[i] < maxv[i]) n[i] = n[i] + 1;
      end
      k = k + 1;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (started && rst_n && !done) begin
      for (int i = 0; i < 2; i++) begin
        int slot;
        logic [6:0] en_e;
        logic [6:0] seg_e;
        bit hide;
        string tag;
        slot = (k / SLOT) % 8;
        en_e = (slot < 7) ? 7'(1 << slot) : 7'h00;
        hide = 1'b0;
        if (slot >= 4 && slot < 7) begin
          hide = 1'b1;
          for (int d = slot; d < 7; d++) if (dig(i, n[i], d) != 0) hide = 1'b0;
        end
        if (blank_display) begin seg_e = 7'h00; tag = "R8"; end
        else if (slot == 7) begin seg_e = 7'h00; tag = "R9"; end
        else if (hide) begin seg_e = 7'h00; tag = "R7"; end
        else begin seg_e = pattern(dig(i, n[i], slot)); tag = "R6 (count R1 R2 R3)"; end
        check(en_g[i] == en_e, "R5", int'(en_g[i]), int'(en_e), "digit_en");
        check(seg_g[i] == seg_e, tag, int'(seg_g[i]), int'(seg_e), "seg");
        check(ov_g[i] == (n[i] == maxv[i]), "R4", int'(ov_g[i]), int'(n[i] == maxv[i]), "ov_flag");
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic frames(int f);
    repeat (f * FRAME) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1'b1;
    #2;
    // R10: reset state
    for (int i = 0; i < 2; i++) begin
      check(en_g[i] == 7'h01, "R10", int'(en_g[i]), 1, "digit_en after reset");
      check(seg_g[i] == 7'h3F, "R10", int'(seg_g[i]), 'h3F, "seg after reset");
      check(ov_g[i] == 1'b0, "R10", int'(ov_g[i]), 0, "ov_flag after reset");
    end

    enable_count = 1'b1;
    frames(300);
    #2;
    check(ov_g[1] == 1'b1, "R4", int'(ov_g[1]), 1, "saturated instance flag");
    check(ov_g[0] == 1'b0, "R4", int'(ov_g[0]), 0, "default instance flag");

    enable_count = 1'b0;          // R2 hold window
    frames(40);
    blank_display = 1'b1;         // R8 window
    frames(10);
    blank_display = 1'b0;

    enable_count = 1'b1;          // R3 single-clock clear with enable high
    reset_count = 1'b1;
    @(negedge clk);
    reset_count = 1'b0;
    #2;
    check(ov_g[1] == 1'b0, "R3", int'(ov_g[1]), 0, "flag after clear");

    frames(1300);                 // R1 long run
    reset_count = 1'b1;
    frames(3);
    reset_count = 1'b0;

    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int c = 0; c < 600 * FRAME; c++) begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        enable_count = lfsr[0] | lfsr[3];
        blank_display = (lfsr[7:4] == 4'hF);
        reset_count = (lfsr[15:8] == 8'h5A);
      end
    end
    enable_count = 1'b0;
    blank_display = 1'b0;
    reset_count = 1'b0;
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule